// File: doc/BRIEF.md
# Stereo Converter Serial Configuration Registers

This block is the configuration front end of a stereo audio converter. A host writes 16-bit control words over a three-wire serial port made of a serial clock, a data line and a latch strobe. Each word carries a 2-bit register address and 9 bits of data. A valid word is written into one of four 9-bit control registers. From those registers the block drives the left and right attenuation codes, the de-emphasis rate select, mute, the zero-detection enable and the channel-routing code.

A mode input selects between software control and hardware control. In software control every output follows the registers. In hardware control the de-emphasis select comes from two pins, and mute still follows its register bit. Attenuation, zero detection and routing are held at their defaults. The register contents are kept, so they take effect again when the block returns to software control.

The serial pins are sampled in the system clock domain. Their rising edges are found by comparing each sampled value with the one taken on the previous clock.

Top module: `acfg_serial_regs`

## Requirements
- R1: While `rst_n` is low, and after it is released, all four registers hold zero. Every output therefore reads 0: attenuation 0 (0 dB), de-emphasis off, mute off, zero detection off and routing code 0 (left to left, right to right).
- R2: `ser_data` is sampled on each rising edge of `ser_clk`, most significant bit first. On a rising edge of `ser_latch` the last 16 bits form a word. Bits [15:11] are the prefix, bits [10:9] are the address (0 to 3 selecting register 0 to 3) and bits [8:0] are the data. The data is written to the addressed register, and no other register changes.
- R3: `atten_l` equals register 0 bits [7:0] and `atten_r` equals register 1 bits [7:0].
- R4: In software control, `deemph_sel` equals register 2 bits [2:1], encoded 00 off, 01 48 kHz, 10 44.1 kHz and 11 32 kHz.
- R5: In software control, `zero_det_en` equals register 2 bit 4.
- R6: In software control, `route` equals register 3 bits [7:4].
- R7: A word whose prefix bits [15:11] are not all zero is discarded, and all four registers keep their values.
- R8: A latch edge that follows a number of serial clock edges other than exactly 16 writes nothing. Every latch edge restarts the bit count.
- R9: In hardware control (`hw_mode` = 1), `deemph_sel` equals `hw_deemph`, using the same encoding as R4.
- R10: In hardware control, `atten_l`, `atten_r`, `route` and `zero_det_en` read 0. The register contents are kept and are output again once `hw_mode` returns to 0.
- R11: `mute` equals register 2 bit 0 in both control modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_latch | input | 1 | Word latch strobe; its rising edge commits the word |
| hw_mode | input | 1 | 1 selects hardware control, 0 selects software control |
| hw_deemph | input | 2 | De-emphasis pins used in hardware control |
| atten_l | output | 8 | Left-channel attenuation code |
| atten_r | output | 8 | Right-channel attenuation code |
| deemph_sel | output | 2 | De-emphasis rate select |
| mute | output | 1 | Mute enable |
| zero_det_en | output | 1 | Zero-detection enable |
| route | output | 4 | Channel output routing code |

## Verification
The assertions assume that the serial pins change synchronously to `clk`. They also assume each level is held for at least one clock, so that every edge of `ser_clk` and `ser_latch` is seen exactly once and a single latch edge never coincides with a shift edge. The bench keeps within this by driving the pins on the falling edge of `clk` and holding each level for two clocks. It also keeps the latch low while data is shifted. With those inputs, the properties can relate a latch edge directly to the bit count and prefix that were shifted before it.

// File: rtl/acfg_serial_regs.sv
module acfg_serial_regs #(
  parameter int WORD_W = 16,
  parameter int DATA_W = 9,
  parameter int ADDR_W = 2,
  parameter int ATT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_latch,
  input  logic             hw_mode,
  input  logic [1:0]       hw_deemph,
  output logic [ATT_W-1:0] atten_l,
  output logic [ATT_W-1:0] atten_r,
  output logic [1:0]       deemph_sel,
  output logic             mute,
  output logic             zero_det_en,
  output logic [3:0]       route
);

  localparam int PFX_W = WORD_W - ADDR_W - DATA_W;
  localparam int NREG  = 1 << ADDR_W;
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(WORD_W + 1);

  logic [2:0]        pin_q, pin_qq;
  logic              sclk_rise, lat_rise;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] cr [NREG];
  logic              commit;
  logic [ADDR_W-1:0] waddr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q  <= '0;
      pin_qq <= '0;
    end else begin
      pin_q  <= {ser_latch, ser_data, ser_clk};
      pin_qq <= pin_q;
    end
  end

  assign sclk_rise = pin_q[0] & ~pin_qq[0];
  assign lat_rise  = pin_q[2] & ~pin_qq[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (lat_rise) begin
      bit_cnt <= '0;
    end else if (sclk_rise) begin
      shreg <= {shreg[WORD_W-2:0], pin_q[1]};
      if (bit_cnt != OVER) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign commit = lat_rise && (bit_cnt == FULL) && (shreg[WORD_W-1 -: PFX_W] == '0);
  assign waddr  = shreg[DATA_W +: ADDR_W];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                               cr[g] <= '0;
      else if (commit && waddr == ADDR_W'(g))   cr[g] <= shreg[DATA_W-1:0];
    end
  end

  assign atten_l     = hw_mode ? '0 : cr[0][ATT_W-1:0];
  assign atten_r     = hw_mode ? '0 : cr[1][ATT_W-1:0];
  assign deemph_sel  = hw_mode ? hw_deemph : cr[2][2:1];
  assign mute        = cr[2][0];
  assign zero_det_en = hw_mode ? 1'b0 : cr[2][4];
  assign route       = hw_mode ? 4'd0 : cr[3][7:4];

  logic unused_bits;
  assign unused_bits = ^{cr[0][DATA_W-1:ATT_W], cr[1][DATA_W-1:ATT_W],
                         cr[2][DATA_W-1:5], cr[2][3], cr[3][DATA_W-1:8], cr[3][3:0]};

  logic [NREG*DATA_W-1:0] all_regs;
  assign all_regs = {cr[3], cr[2], cr[1], cr[0]};

  p_bad_prefix_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && shreg[WORD_W-1 -: PFX_W] != '0) |=> $stable(all_regs));

  p_short_long_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && bit_cnt != FULL) |=> $stable(all_regs));

  p_latch_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lat_rise |=> bit_cnt == '0);

  p_write_cr0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && bit_cnt == FULL && shreg[WORD_W-1 -: PFX_W] == '0 && shreg[DATA_W +: ADDR_W] == '0)
      |=> (cr[0] == $past(shreg[DATA_W-1:0])) && $stable({cr[3], cr[2], cr[1]}));

  p_hw_defaults_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hw_mode |-> (atten_l == '0 && atten_r == '0 && route == '0 && !zero_det_en));

  p_no_latch_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_rise |=> $stable(all_regs));

endmodule

// File: tb/sim_acfg_serial_regs.sv
module sim_acfg_serial_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_latch = 1'b0;
  logic hw_mode = 1'b0;
  logic [1:0] hw_deemph = 2'b00;
  logic [7:0] atten_l, atten_r;
  logic [1:0] deemph_sel;
  logic mute, zero_det_en;
  logic [3:0] route;

  int n_chk = 0, n_bad = 0;
  logic [8:0] mdl [4];

  always #10 clk = ~clk;

  acfg_serial_regs u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_latch(ser_latch), .hw_mode(hw_mode), .hw_deemph(hw_deemph),
    .atten_l(atten_l), .atten_r(atten_r), .deemph_sel(deemph_sel),
    .mute(mute), .zero_det_en(zero_det_en), .route(route));

  localparam int NV = 10;
  localparam logic [15:0] VEC [NV] = '{
    16'h00A5, 16'h033C, 16'h0403, 16'h0415, 16'h06A0,
    16'h0406, 16'h01FF, 16'h0750, 16'h0200, 16'h0400 };

  function automatic logic [23:0] expect_out(input logic hw, input logic [1:0] pins);
    logic [23:0] e;
    if (hw) e = {8'd0, 8'd0, pins, mdl[2][0], 1'b0, 4'd0};
    else    e = {mdl[0][7:0], mdl[1][7:0], mdl[2][2:1], mdl[2][0], mdl[2][4], mdl[3][7:4]};
    return e;
  endfunction

  task automatic check(input string req, input logic [23:0] exp_v);
    logic [23:0] got;
    got = {atten_l, atten_r, deemph_sel, mute, zero_det_en, route};
    n_chk++;
    if (got !== exp_v) begin
      n_bad++;
      $display("FAIL %s: got %06h expected %06h", req, got, exp_v);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = w[i];
      ser_clk = 1'b0;
      wait_clk(2);
      ser_clk = 1'b1;
      wait_clk(2);
    end
    ser_clk = 1'b0;
    wait_clk(2);
    ser_latch = 1'b1;
    wait_clk(2);
    ser_latch = 1'b0;
    wait_clk(4);
  endtask

  task automatic write_word(input logic [15:0] w);
    send_bits({16'd0, w}, 16);
    if (w[15:11] == 5'd0) mdl[w[10:9]] = w[8:0];
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) mdl[i] = '0;
    wait_clk(3);
    check("R1 during reset", 24'd0);
    rst_n = 1'b1;
    wait_clk(2);
    check("R1 after reset", 24'd0);

    for (int v = 0; v < NV; v++) begin
      write_word(VEC[v]);
      check($sformatf("R2 R3 R4 R5 R6 R11 vector %0d", v), expect_out(1'b0, 2'b00));
    end

    write_word(16'h00C3);
    write_word(16'h0281);
    write_word(16'h0417);
    write_word(16'h07F0);
    check("R2 all registers loaded", expect_out(1'b0, 2'b00));

    send_bits({16'd0, 16'h8055}, 16);
    check("R7 prefix msb set discarded", expect_out(1'b0, 2'b00));
    send_bits({16'd0, 16'h0C00}, 16);
    check("R7 prefix lsb set discarded", expect_out(1'b0, 2'b00));

    send_bits({17'd0, 15'h0412}, 15);
    check("R8 15-bit word discarded", expect_out(1'b0, 2'b00));
    send_bits({15'd0, 1'b0, 16'h0011}, 17);
    check("R8 17-bit word discarded", expect_out(1'b0, 2'b00));
    write_word(16'h0011);
    check("R8 count restarts after bad latch", expect_out(1'b0, 2'b00));

    hw_mode = 1'b1;
    for (int p = 0; p < 4; p++) begin
      hw_deemph = 2'(p);
      wait_clk(1);
      check($sformatf("R9 R10 R11 hw pins %0d", p), expect_out(1'b1, 2'(p)));
    end
    write_word(16'h0401);
    check("R11 mute set in hardware control", expect_out(1'b1, hw_deemph));
    write_word(16'h0400);
    check("R11 mute clear in hardware control", expect_out(1'b1, hw_deemph));
    write_word(16'h0415);
    hw_mode = 1'b0;
    wait_clk(1);
    check("R10 registers reappear in software control", expect_out(1'b0, 2'b00));

    rst_n = 1'b0;
    wait_clk(2);
    for (int i = 0; i < 4; i++) mdl[i] = '0;
    rst_n = 1'b1;
    wait_clk(2);
    check("R1 reset clears loaded registers", 24'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule